// File: doc/BRIEF.md
# Capability Fault Recorder and Privileged Register Gate

This unit sits beside the capability register file of a processor core. It answers, in the same cycle, whether an instruction may touch a given capability register number. Five privileged numbers (27 to 31) are each guarded by their own access bit inside the current program-counter capability; all other numbers are always open. When an access is refused, the unit supplies the matching 8-bit fault code.

It also records capability faults. A fault can come from the core as an explicit fault-kind index, or from a refused privileged access that the core marks as a real attempt. On the clock edge that takes a fault, the unit writes a 16-bit cause word (fault code and register field), raises a one-cycle exception pulse tagged with its class (trap class for call and return traps, general capability error otherwise), saves the program-counter capability with its offset replaced by the faulting PC into its exception-capability slot, and loads the next-PC and delayed-PC capabilities from the kernel code capability. An exception return loads both of those from the saved exception capability.

Capabilities are carried flat. With default parameters a capability is 257 bits: length in bits 63..0, base in 127..64, offset in 191..128, sealed flag at 192, fifteen hardware permission bits at 207..193, software permissions, object type, padding, and the tag at bit 256.

Top module: `cap_exc_unit`

## Requirements
- R1: `acc_denied` is combinational and is high only when `acc_regnum` is 27, 28, 29, 30 or 31 and the gating bit of `pcc_in` for that number is 0; the gating bits are 206 for 27, 207 for 28, 205 for 29, 204 for 30 and 203 for 31. Any other register number is never denied.
- R2: `acc_code` is 0x1d, 0x1e, 0x1c, 0x1b or 0x1a when register 27, 28, 29, 30 or 31 respectively is denied, and 0x00 whenever `acc_denied` is low.
- R3: On the rising edge that takes a fault, `cause` becomes the fault code in bits 15..8 and the register field in bits 7..0; the register field is the 5-bit register number zero-extended, or 0xff for an explicit fault with `flt_has_reg` low.
- R4: An explicit fault-kind index k maps to its code as follows: k 0..10 give 0x00..0x0a, k 11..18 give 0x10..0x17, k 19..23 give 0x1a..0x1e, and any k above 23 is recorded as 0x08 (user-defined).
- R5: `exc_valid` is high for exactly the cycle after a fault edge, and `exc_trap` is then 1 when the recorded code is 0x05 or 0x06 and 0 for every other code.
- R6: On a fault edge, `epcc_out` becomes `pcc_in` with bits 191..128 replaced by `fault_pc`, and both `next_pcc` and `delayed_pcc` become `kcc_in`.
- R7: On an exception-return edge with no fault, `next_pcc` and `delayed_pcc` both become the value `epcc_out` held before that edge; `epcc_out` and `cause` do not change.
- R8: An explicit fault (`flt_valid`) takes precedence over a refused access in the same cycle, and any fault takes precedence over an exception return in the same cycle.
- R9: A refused access is recorded as a fault only when `acc_valid` is high; an `acc_valid` on an open register changes neither `cause` nor the slots and raises no `exc_valid`.
- R10: While `rst_n` is low at a rising edge, `cause`, `exc_valid`, `exc_trap`, `epcc_out`, `next_pcc` and `delayed_pcc` all become zero.
- R11: On an edge with neither a fault nor a return, `cause`, `epcc_out`, `next_pcc` and `delayed_pcc` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_regnum | input | 5 | Capability register number being accessed |
| acc_valid | input | 1 | The access is a real attempt; a refusal becomes a fault |
| acc_denied | output | 1 | Access to `acc_regnum` is refused |
| acc_code | output | 8 | Fault code of the refusal, 0x00 when open |
| flt_valid | input | 1 | Explicit capability fault strobe |
| flt_kind | input | 5 | Fault-kind index of the explicit fault |
| flt_has_reg | input | 1 | The explicit fault names a register |
| flt_regnum | input | 5 | Register named by the explicit fault |
| eret_valid | input | 1 | Exception return strobe |
| pcc_in | input | 257 | Current program-counter capability |
| kcc_in | input | 257 | Kernel code capability (register 29) |
| fault_pc | input | 64 | Program counter of the faulting instruction |
| cause | output | 16 | Capability cause word {code, register field} |
| exc_valid | output | 1 | One-cycle exception pulse after a fault |
| exc_trap | output | 1 | 1 for trap class, 0 for general capability error |
| epcc_out | output | 257 | Saved exception capability (register 31 slot) |
| next_pcc | output | 257 | Next program-counter capability |
| delayed_pcc | output | 257 | Delayed program-counter capability |

## Verification
The hardest situation to reach is a single cycle in which an explicit fault, a refused privileged access and an exception return all arrive together, because only then do both precedence rules act on the same edge. The random stimulus raises each strobe often and biases register numbers toward 27 to 31 with random gating bits, so triple collisions recur, and directed cases force them with known values. Return behaviour is only meaningful after the exception slot holds a non-zero capability, so the directed sequence takes a fault with a known capability before issuing a return.

// File: rtl/cap_exc_pkg.sv
// Package: shared constants and mapping functions of the capability fault unit.
// Assumes register numbers are at least 5 bits wide so that 27..31 exist.
package cap_exc_pkg;

    // Default field widths of a flat capability
    localparam int ADDR_W_DEF  = 64;
    localparam int OTYPE_W_DEF = 24;
    localparam int SWP_W_DEF   = 16;
    localparam int HWP_W_DEF   = 15;
    localparam int PAD_W_DEF   = 8;

    // Hardware permission bit indices that gate privileged registers
    localparam int PERM_EXC_SLOT = 10;
    localparam int PERM_KDATA    = 11;
    localparam int PERM_KCODE    = 12;
    localparam int PERM_KRES1    = 13;
    localparam int PERM_KRES2    = 14;

    // Privileged register window
    localparam int PRIV_FIRST = 27;
    localparam int NUM_PRIV   = 5;

    // Fixed code values
    localparam logic [7:0] CODE_NONE      = 8'h00;
    localparam logic [7:0] CODE_CALL_TRAP = 8'h05;
    localparam logic [7:0] CODE_RET_TRAP  = 8'h06;
    localparam logic [7:0] CODE_USER      = 8'h08;
    localparam logic [7:0] FIELD_NO_REG   = 8'hff;

    // Kind-index groups (contiguous runs of codes)
    localparam int GRP0_LAST  = 10;
    localparam int GRP1_FIRST = 11;
    localparam int GRP1_LAST  = 18;
    localparam int GRP2_FIRST = 19;
    localparam int GRP2_LAST  = 23;
    localparam logic [7:0] GRP1_BASE = 8'h10;
    localparam logic [7:0] GRP2_BASE = 8'h1a;

    // Gating permission bit for privileged slot i (register PRIV_FIRST+i)
    function automatic int priv_perm_bit(input int i);
        case (i)
            0:       return PERM_KRES1;
            1:       return PERM_KRES2;
            2:       return PERM_KCODE;
            3:       return PERM_KDATA;
            default: return PERM_EXC_SLOT;
        endcase
    endfunction

    // Refusal code for privileged slot i
    function automatic logic [7:0] priv_code(input int i);
        case (i)
            0:       return 8'h1d;
            1:       return 8'h1e;
            2:       return 8'h1c;
            3:       return 8'h1b;
            default: return 8'h1a;
        endcase
    endfunction

    // Trap-class membership of a recorded code
    function automatic logic is_trap_code(input logic [7:0] c);
        return (c == CODE_CALL_TRAP) || (c == CODE_RET_TRAP);
    endfunction

endpackage

// File: rtl/cap_access_gate.sv
// Module: cap_access_gate
// Decides combinationally whether a capability register number may be
// accessed under the given hardware permission bits, and yields the
// refusal code. One comparator per privileged register is generated.
// Assumes REG_W >= 5.
module cap_access_gate
    import cap_exc_pkg::*;
#(
    parameter int REG_W  = 5,
    parameter int HWP_W  = HWP_W_DEF,
    parameter int CODE_W = 8
) (
    input  logic [REG_W-1:0]  regnum,
    input  logic [HWP_W-1:0]  hw_perms,
    output logic              denied,
    output logic [CODE_W-1:0] code
);

    logic [NUM_PRIV-1:0] hit;
    logic [NUM_PRIV-1:0] blocked;

    for (genvar g = 0; g < NUM_PRIV; g++) begin : g_priv
        localparam int PBIT = priv_perm_bit(g);
        // match this privileged number and test its gating bit
        assign hit[g]     = (regnum == REG_W'(PRIV_FIRST + g));
        assign blocked[g] = hit[g] & ~hw_perms[PBIT];
    end

    // merge the refusal of the (at most one) matching slot
    always_comb begin
        code = '0;
        for (int i = 0; i < NUM_PRIV; i++) begin
            if (blocked[i]) begin
                code = CODE_W'(priv_code(i));
            end
        end
    end

    assign denied = |blocked;

endmodule

// File: rtl/cap_fault_encoder.sv
// Module: cap_fault_encoder
// Maps an explicit fault-kind index to its 8-bit fault code. Indices form
// three contiguous runs of codes; anything past the last run is recorded
// as a user-defined fault. Purely combinational.
module cap_fault_encoder
    import cap_exc_pkg::*;
#(
    parameter int KIND_W = 5,
    parameter int CODE_W = 8
) (
    input  logic [KIND_W-1:0] kind,
    output logic [CODE_W-1:0] code
);

    logic [7:0] k8;
    logic [7:0] mapped;

    assign k8 = 8'(kind);

    // pick the run the index falls into and offset from its base code
    always_comb begin
        if (k8 <= 8'(GRP0_LAST)) begin
            mapped = k8;
        end else if (k8 <= 8'(GRP1_LAST)) begin
            mapped = GRP1_BASE + (k8 - 8'(GRP1_FIRST));
        end else if (k8 <= 8'(GRP2_LAST)) begin
            mapped = GRP2_BASE + (k8 - 8'(GRP2_FIRST));
        end else begin
            mapped = CODE_USER;
        end
    end

    assign code = CODE_W'(mapped);

endmodule

// File: rtl/cap_cause_reg.sv
// Module: cap_cause_reg
// Holds the capability cause word and the one-cycle exception pulse with
// its class. Loads on log_en, holds otherwise. Synchronous active-low reset.
module cap_cause_reg
    import cap_exc_pkg::*;
#(
    parameter int CODE_W  = 8,
    parameter int FIELD_W = 8,
    localparam int CAUSE_W = CODE_W + FIELD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               log_en,
    input  logic [CODE_W-1:0]  log_code,
    input  logic [FIELD_W-1:0] log_field,
    output logic [CAUSE_W-1:0] cause,
    output logic               exc_valid,
    output logic               exc_trap
);

    // cause word: code above register field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause <= '0;
        end else if (log_en) begin
            cause <= {log_code, log_field};
        end
    end

    // exception pulse and class, valid for the cycle after a fault
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_valid <= 1'b0;
            exc_trap  <= 1'b0;
        end else begin
            exc_valid <= log_en;
            exc_trap  <= log_en & is_trap_code(8'(log_code));
        end
    end

endmodule

// File: rtl/cap_slot_ctrl.sv
// Module: cap_slot_ctrl
// Keeps the exception-capability slot and the next / delayed program-counter
// capabilities. Fault entry saves the current capability with its offset
// replaced by the faulting PC and redirects to the kernel code capability;
// return redirects to the saved slot. Entry must dominate return at the
// caller; here entry is tested first as well.
module cap_slot_ctrl #(
    parameter int ADDR_W = 64,
    parameter int CAP_W  = 257,
    parameter int OFF_LO = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter,
    input  logic              leave,
    input  logic [CAP_W-1:0]  cur_cap,
    input  logic [CAP_W-1:0]  kcode_cap,
    input  logic [ADDR_W-1:0] fault_addr,
    output logic [CAP_W-1:0]  exc_cap,
    output logic [CAP_W-1:0]  nxt_cap,
    output logic [CAP_W-1:0]  dly_cap
);

    logic [CAP_W-1:0] saved_cap;

    // current capability with the offset field overwritten
    always_comb begin
        saved_cap = cur_cap;
        saved_cap[OFF_LO +: ADDR_W] = fault_addr;
    end

    // exception slot: written only on entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_cap <= '0;
        end else if (enter) begin
            exc_cap <= saved_cap;
        end
    end

    // next and delayed capabilities always move together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_cap <= '0;
            dly_cap <= '0;
        end else if (enter) begin
            nxt_cap <= kcode_cap;
            dly_cap <= kcode_cap;
        end else if (leave) begin
            nxt_cap <= exc_cap;
            dly_cap <= exc_cap;
        end
    end

endmodule

// File: rtl/cap_exc_unit.sv
// Module: cap_exc_unit (top)
// Capability register-access gate plus fault recorder. Selects between an
// explicit fault and a refused real access (explicit wins), forms the cause
// word, and drives the capability slots. Fault beats return in one cycle.
// Assumes a flat capability: length, base, offset from bit 0 up, then the
// sealed flag, hardware permissions, software permissions, type, pad, tag.
module cap_exc_unit
    import cap_exc_pkg::*;
#(
    parameter int ADDR_W  = ADDR_W_DEF,
    parameter int OTYPE_W = OTYPE_W_DEF,
    parameter int SWP_W   = SWP_W_DEF,
    parameter int HWP_W   = HWP_W_DEF,
    parameter int PAD_W   = PAD_W_DEF,
    parameter int REG_W   = 5,
    parameter int KIND_W  = 5,
    parameter int CODE_W  = 8,
    parameter int FIELD_W = 8,
    localparam int CAP_W   = 1 + PAD_W + OTYPE_W + SWP_W + HWP_W + 1 + 3 * ADDR_W,
    localparam int CAUSE_W = CODE_W + FIELD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [REG_W-1:0]   acc_regnum,
    input  logic               acc_valid,
    output logic               acc_denied,
    output logic [CODE_W-1:0]  acc_code,
    input  logic               flt_valid,
    input  logic [KIND_W-1:0]  flt_kind,
    input  logic               flt_has_reg,
    input  logic [REG_W-1:0]   flt_regnum,
    input  logic               eret_valid,
    input  logic [CAP_W-1:0]   pcc_in,
    input  logic [CAP_W-1:0]   kcc_in,
    input  logic [ADDR_W-1:0]  fault_pc,
    output logic [CAUSE_W-1:0] cause,
    output logic               exc_valid,
    output logic               exc_trap,
    output logic [CAP_W-1:0]   epcc_out,
    output logic [CAP_W-1:0]   next_pcc,
    output logic [CAP_W-1:0]   delayed_pcc
);

    localparam int OFF_LO  = 2 * ADDR_W;
    localparam int PERM_LO = 3 * ADDR_W + 1;

    logic [CODE_W-1:0]  kind_code;
    logic               acc_fault;
    logic               any_fault;
    logic               do_return;
    logic [CODE_W-1:0]  sel_code;
    logic [FIELD_W-1:0] sel_field;

    // register-access gate on the current capability's permission bits
    cap_access_gate #(
        .REG_W (REG_W),
        .HWP_W (HWP_W),
        .CODE_W(CODE_W)
    ) u_gate (
        .regnum  (acc_regnum),
        .hw_perms(pcc_in[PERM_LO +: HWP_W]),
        .denied  (acc_denied),
        .code    (acc_code)
    );

    // explicit fault kind to code
    cap_fault_encoder #(
        .KIND_W(KIND_W),
        .CODE_W(CODE_W)
    ) u_enc (
        .kind(flt_kind),
        .code(kind_code)
    );

    // fault source selection: explicit first, refused real access second
    always_comb begin
        acc_fault = acc_valid & acc_denied;
        any_fault = flt_valid | acc_fault;
        do_return = eret_valid & ~any_fault;
        if (flt_valid) begin
            sel_code  = kind_code;
            sel_field = flt_has_reg ? FIELD_W'(flt_regnum) : FIELD_W'(FIELD_NO_REG);
        end else begin
            sel_code  = acc_code;
            sel_field = FIELD_W'(acc_regnum);
        end
    end

    cap_cause_reg #(
        .CODE_W (CODE_W),
        .FIELD_W(FIELD_W)
    ) u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .log_en   (any_fault),
        .log_code (sel_code),
        .log_field(sel_field),
        .cause    (cause),
        .exc_valid(exc_valid),
        .exc_trap (exc_trap)
    );

    cap_slot_ctrl #(
        .ADDR_W(ADDR_W),
        .CAP_W (CAP_W),
        .OFF_LO(OFF_LO)
    ) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .enter     (any_fault),
        .leave     (do_return),
        .cur_cap   (pcc_in),
        .kcode_cap (kcc_in),
        .fault_addr(fault_pc),
        .exc_cap   (epcc_out),
        .nxt_cap   (next_pcc),
        .dly_cap   (delayed_pcc)
    );

endmodule

// File: rtl/cap_exc_unit_chk.sv
// Module: cap_exc_unit_chk
// Port-level properties of cap_exc_unit, attached with bind below.
module cap_exc_unit_chk #(
    parameter int ADDR_W  = 64,
    parameter int REG_W   = 5,
    parameter int KIND_W  = 5,
    parameter int CODE_W  = 8,
    parameter int CAP_W   = 257,
    parameter int CAUSE_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [REG_W-1:0]   acc_regnum,
    input logic               acc_valid,
    input logic               acc_denied,
    input logic [CODE_W-1:0]  acc_code,
    input logic               flt_valid,
    input logic [KIND_W-1:0]  flt_kind,
    input logic               flt_has_reg,
    input logic [REG_W-1:0]   flt_regnum,
    input logic               eret_valid,
    input logic [CAP_W-1:0]   pcc_in,
    input logic [CAP_W-1:0]   kcc_in,
    input logic [ADDR_W-1:0]  fault_pc,
    input logic [CAUSE_W-1:0] cause,
    input logic               exc_valid,
    input logic               exc_trap,
    input logic [CAP_W-1:0]   epcc_out,
    input logic [CAP_W-1:0]   next_pcc,
    input logic [CAP_W-1:0]   delayed_pcc
);

    logic fault_now;
    assign fault_now = flt_valid | (acc_valid & acc_denied);

    AST_OPEN_REGS: assert property (@(posedge clk) disable iff (!rst_n) (acc_regnum < REG_W'(27)) |-> !acc_denied); // R1
    AST_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !acc_denied |-> (acc_code == '0)); // R2
    AST_NOREG_FIELD: assert property (@(posedge clk) disable iff (!rst_n) (flt_valid && !flt_has_reg) |=> (cause[7:0] == 8'hff)); // R3
    AST_PULSE_AFTER: assert property (@(posedge clk) disable iff (!rst_n) fault_now |=> exc_valid); // R5
    AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (!rst_n) exc_valid |-> (exc_trap == (cause[15:8] == 8'h05 || cause[15:8] == 8'h06))); // R5
    AST_ENTRY_KCODE: assert property (@(posedge clk) disable iff (!rst_n) fault_now |=> (next_pcc == $past(kcc_in))); // R6
    AST_RETURN_SLOT: assert property (@(posedge clk) disable iff (!rst_n) (eret_valid && !fault_now) |=> (next_pcc == $past(epcc_out))); // R7
    AST_FAULT_WINS: assert property (@(posedge clk) disable iff (!rst_n) (eret_valid && fault_now) |=> (delayed_pcc == $past(kcc_in))); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !fault_now |=> ($stable(cause) && $stable(epcc_out))); // R11

endmodule

bind cap_exc_unit cap_exc_unit_chk #(
    .ADDR_W (ADDR_W),
    .REG_W  (REG_W),
    .KIND_W (KIND_W),
    .CODE_W (CODE_W),
    .CAP_W  (CAP_W),
    .CAUSE_W(CAUSE_W)
) u_chk (.*);

// File: tb/tb_cap_exc_unit.sv
`timescale 1ns/1ps
module tb_cap_exc_unit;

    localparam int CAP_W = 257;
    localparam int OFF_LO = 128;
    localparam int PERM_LO = 193;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [4:0]       acc_regnum = '0;
    logic             acc_valid = 1'b0;
    logic             acc_denied;
    logic [7:0]       acc_code;
    logic             flt_valid = 1'b0;
    logic [4:0]       flt_kind = '0;
    logic             flt_has_reg = 1'b0;
    logic [4:0]       flt_regnum = '0;
    logic             eret_valid = 1'b0;
    logic [CAP_W-1:0] pcc_in = '0;
    logic [CAP_W-1:0] kcc_in = '0;
    logic [63:0]      fault_pc = '0;
    logic [15:0]      cause;
    logic             exc_valid;
    logic             exc_trap;
    logic [CAP_W-1:0] epcc_out;
    logic [CAP_W-1:0] next_pcc;
    logic [CAP_W-1:0] delayed_pcc;

    cap_exc_unit dut (.*);

    always #2 clk = ~clk;

    int checks = 0;
    int failures = 0;

    // reference state
    logic [15:0]      m_cause = '0;
    logic             m_exc = 1'b0;
    logic             m_trap = 1'b0;
    logic [CAP_W-1:0] m_epcc = '0;
    logic [CAP_W-1:0] m_next = '0;

    task automatic chk(input logic [CAP_W-1:0] act, input logic [CAP_W-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected gate result {denied, code}
    function automatic logic [8:0] ref_gate(input logic [4:0] rn, input logic [CAP_W-1:0] p);
        case (rn)
            5'd27: return p[206] ? 9'h000 : 9'h11d;
            5'd28: return p[207] ? 9'h000 : 9'h11e;
            5'd29: return p[205] ? 9'h000 : 9'h11c;
            5'd30: return p[204] ? 9'h000 : 9'h11b;
            5'd31: return p[203] ? 9'h000 : 9'h11a;
            default: return 9'h000;
        endcase
    endfunction

    function automatic logic [7:0] ref_kind(input logic [4:0] k);
        if (k <= 5'd10) return {3'b0, k};
        if (k <= 5'd18) return 8'h10 + 8'(k - 5'd11);
        if (k <= 5'd23) return 8'h1a + 8'(k - 5'd19);
        return 8'h08;
    endfunction

    function automatic logic [CAP_W-1:0] rand_cap();
        logic [CAP_W-1:0] v;
        for (int i = 0; i < CAP_W; i++) v[i] = 1'($urandom);
        return v;
    endfunction

    // drive one cycle, check gate, clock, update reference, check registers
    task automatic step(input logic [4:0] rn, input logic av, input logic fv, input logic [4:0] fk,
                        input logic fh, input logic [4:0] fr, input logic ev,
                        input logic [CAP_W-1:0] p, input logic [CAP_W-1:0] k, input logic [63:0] pc);
        logic [8:0] g;
        logic       f;
        logic [7:0] code;
        logic [7:0] field;
        acc_regnum = rn; acc_valid = av; flt_valid = fv; flt_kind = fk;
        flt_has_reg = fh; flt_regnum = fr; eret_valid = ev;
        pcc_in = p; kcc_in = k; fault_pc = pc;
        #1;
        g = ref_gate(rn, p);
        chk(CAP_W'(acc_denied), CAP_W'(g[8]), "R1 acc_denied");
        chk(CAP_W'(acc_code), CAP_W'(g[7:0]), "R2 acc_code");
        f = fv | (av & g[8]);
        if (fv) begin
            code = ref_kind(fk);
            field = fh ? {3'b0, fr} : 8'hff;
        end else begin
            code = g[7:0];
            field = {3'b0, rn};
        end
        @(posedge clk);
        if (f) begin
            m_cause = {code, field};
            m_exc = 1'b1;
            m_trap = (code == 8'h05) || (code == 8'h06);
            m_epcc = p;
            m_epcc[OFF_LO +: 64] = pc;
            m_next = k;
        end else begin
            m_exc = 1'b0;
            m_trap = 1'b0;
            if (ev) m_next = m_epcc;
        end
        @(negedge clk);
        chk(CAP_W'(cause), CAP_W'(m_cause), "R3 cause");
        chk(CAP_W'(exc_valid), CAP_W'(m_exc), "R5 exc_valid");
        chk(CAP_W'(exc_trap), CAP_W'(m_trap), "R5 exc_trap");
        chk(epcc_out, m_epcc, "R6 epcc_out");
        chk(next_pcc, m_next, "R6 R7 next_pcc");
        chk(delayed_pcc, m_next, "R6 R7 delayed_pcc");
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [CAP_W-1:0] pa;
        logic [CAP_W-1:0] ka;
        logic [15:0]      held;
        void'($urandom(32'd20240611));
        // hold reset with garbage on the strobes' data
        pcc_in = rand_cap(); kcc_in = rand_cap();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk(CAP_W'(cause), '0, "R10 cause");
        chk(CAP_W'(exc_valid), '0, "R10 exc_valid");
        chk(CAP_W'(exc_trap), '0, "R10 exc_trap");
        chk(epcc_out, '0, "R10 epcc_out");
        chk(next_pcc, '0, "R10 next_pcc");
        chk(delayed_pcc, '0, "R10 delayed_pcc");
        rst_n = 1'b1;

        // R1 R2: each privileged register with its gate bit cleared, all others set
        for (int r = 27; r < 32; r++) begin
            pa = '1;
            case (r)
                27: pa[206] = 1'b0;
                28: pa[207] = 1'b0;
                29: pa[205] = 1'b0;
                30: pa[204] = 1'b0;
                default: pa[203] = 1'b0;
            endcase
            step(5'(r), 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, pa, '0, 64'd0);
        end
        // R1: open register 26 with all permission bits clear
        step(5'd26, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, '0, '0, 64'd0);

        // R4 R3: explicit load-permission fault naming register 3 -> 0x1203
        pa = rand_cap(); ka = rand_cap();
        step(5'd0, 1'b0, 1'b1, 5'd13, 1'b1, 5'd3, 1'b0, pa, ka, 64'h1234_5678_9abc_def0);
        chk(CAP_W'(cause), CAP_W'(16'h1203), "R4 kind13");
        // R4 R3: kind above the last run, no register -> 0x08ff
        step(5'd0, 1'b0, 1'b1, 5'd30, 1'b0, 5'd7, 1'b0, pa, ka, 64'h40);
        chk(CAP_W'(cause), CAP_W'(16'h08ff), "R4 kind30");
        // R5: call trap is trap class
        step(5'd0, 1'b0, 1'b1, 5'd5, 1'b1, 5'd9, 1'b0, pa, ka, 64'h80);
        chk(CAP_W'(exc_trap), CAP_W'(1), "R5 call trap");
        // R5: return trap, then the next idle cycle drops the pulse
        step(5'd0, 1'b0, 1'b1, 5'd6, 1'b0, 5'd0, 1'b0, pa, ka, 64'h84);
        step(5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, pa, ka, 64'h0);
        chk(CAP_W'(exc_valid), CAP_W'(0), "R5 pulse ends");

        // R6: entry saves pcc with new offset; R7: return reloads from slot
        pa = rand_cap(); ka = rand_cap();
        step(5'd0, 1'b0, 1'b1, 5'd2, 1'b1, 5'd1, 1'b0, pa, ka, 64'hdead_beef_0000_0010);
        chk(epcc_out[OFF_LO +: 64], CAP_W'(64'hdead_beef_0000_0010), "R6 offset");
        held = cause;
        step(5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1, rand_cap(), rand_cap(), 64'h0);
        chk(next_pcc[PERM_LO +: 15], CAP_W'(pa[PERM_LO +: 15]), "R7 perms from slot");
        chk(CAP_W'(cause), CAP_W'(held), "R7 cause unchanged");

        // R9: real access to an open privileged register records nothing
        pa = '1;
        held = cause;
        step(5'd29, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, pa, rand_cap(), 64'h0);
        chk(CAP_W'(cause), CAP_W'(held), "R9 open access");
        chk(CAP_W'(exc_valid), CAP_W'(0), "R9 no pulse");
        // R9: refused real access to 31 records 0x1a1f
        pa[203] = 1'b0;
        step(5'd31, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, pa, rand_cap(), 64'h0);
        chk(CAP_W'(cause), CAP_W'(16'h1a1f), "R9 refused access");

        // R8: explicit fault + refused access + return, all together
        ka = rand_cap();
        step(5'd31, 1'b1, 1'b1, 5'd1, 1'b1, 5'd4, 1'b1, pa, ka, 64'h100);
        chk(CAP_W'(cause), CAP_W'(16'h0104), "R8 explicit wins");
        chk(next_pcc, ka, "R8 fault beats return");

        // R11 and all above: random traffic
        for (int n = 0; n < 400; n++) begin
            logic [4:0] rn;
            rn = ($urandom % 2) ? 5'(27 + ($urandom % 5)) : 5'($urandom);
            pa = rand_cap();
            step(rn, ($urandom % 3) == 0, ($urandom % 4) == 0, 5'($urandom),
                 1'($urandom), 5'($urandom), ($urandom % 4) == 0,
                 pa, rand_cap(), {$urandom, $urandom});
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule